// File: doc/BRIEF.md
# Serial Two-Byte Command Decoder

This block is a three-wire serial slave. It takes an active-low select, a shift clock and a data line, and samples all three in the core clock domain through two-flop synchronisers. It collects bits into bytes and pairs the bytes into two-byte commands. A leading byte is marked by a set top bit and carries a 4-bit command number and three high payload bits. A trailing byte has its top bit clear and carries seven low payload bits. Together they form a 10-bit payload.

Command 0 loads a display-memory address pointer. Commands 1 and 2 build a 20-bit write to display memory, and the pointer steps forward after each write. Commands 3 to 13 each load one 10-bit slot of a control register file. The display-enable flag is bit 0 of the command-4 slot. Commands 14 and 15 are reserved.

After reset the block stays deaf until its select line has been seen high once. That release also arms the block.

Top module: `sdec_top`

## Requirements
- R1: Data is captured most significant bit first on each rising shift-clock edge while csN is low, and eight captured bits make one byte.
- R2: Driving csN high discards a partly received byte and any pending leading byte, so the next byte starts a fresh command.
- R3: A byte with bit 7 at 0 that arrives where a leading byte is expected is discarded with no effect, and the decoder keeps waiting for a leading byte.
- R4: The leading byte is {1, cmd[3:0], p[9:7]} and the trailing byte is {0, p[6:0]}. Command 0 loads the select flag from p[9], the row pointer from p[8:5] (0 to 11) and the column pointer from p[4:0] (0 to 23).
- R5: Command 1 stores its payload in a holding register. Command 2 raises memWe for exactly one cycle with memData = {hold, payload}, memRow/memCol = the pointer, and memTarget set as follows: 0 if the select flag is 0, 1 (sub-screen line) if the flag is 1 and the column is even, 2 (main-screen line) if the flag is 1 and the column is odd. The holding register keeps its value across writes.
- R6: After each command-2 write the column advances by one. Column 23 wraps to column 0 of the next row, and row 11 wraps to row 0.
- R7: Command n, for n from 3 to 13, loads its payload into ctlRegs[(n-3)*10 +: 10] and changes no other slot.
- R8: Commands 14 and 15 change no register, no pointer and raise no write.
- R9: Reset clears all register slots and the pointer, so displayOn (bit 0 of the command-4 slot) is 0.
- R10: Until csN has been sampled high once after reset, no command takes effect.
- R11: A byte with bit 7 at 1 that arrives where a trailing byte is expected replaces the pending command and becomes the new leading byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data |
| memWe | output | 1 | One-cycle display-memory write strobe |
| memTarget | output | 2 | Write target: 0 character, 1 sub-screen line, 2 main-screen line |
| memRow | output | 4 | Row of the write |
| memCol | output | 5 | Column of the write |
| memData | output | 20 | Write data {hold, command-2 payload} |
| ptrRow | output | 4 | Current row pointer |
| ptrCol | output | 5 | Current column pointer |
| ctlRegs | output | 110 | Eleven 10-bit control slots for commands 3 to 13 |
| displayOn | output | 1 | Display enable, bit 0 of the command-4 slot |

## Verification
A slip in the bit counter or the framing state makes every later command land in the wrong slot. That error shows on ctlRegs within one command of the fault, and it lasts until a select pulse realigns the decoder. A wrong pointer step shows in the memRow/memCol of the next write strobe. The sweep writes all 288 positions, so a bad wrap surfaces at the first row crossing. A reserved or stray byte that leaks through alters a slot or adds a write strobe, and the next port check sees it.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int PAYLOAD_W = 10;
  localparam int FIRST_REG_CMD = 3;
  localparam int LAST_REG_CMD = 13;
  localparam int NUM_REGS = LAST_REG_CMD - FIRST_REG_CMD + 1;
  localparam int SCREEN_CMD = 4;
  localparam int DISP_SLOT = SCREEN_CMD - FIRST_REG_CMD;

  typedef enum logic [1:0] {
    TGT_CHAR     = 2'd0,
    TGT_SUBLINE  = 2'd1,
    TGT_MAINLINE = 2'd2
  } target_e;

  typedef struct packed {
    logic                 ldPtr;
    logic                 ldHold;
    logic                 wrMem;
    logic                 ldReg;
    logic [3:0]           regIdx;
    logic [PAYLOAD_W-1:0] payload;
  } strobe_t;
endpackage

// File: rtl/sdec_ctrl.sv
module sdec_ctrl
  import sdec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t st,
  output logic    armed
);
  typedef enum logic {FR_HEAD, FR_TAIL} frame_e;

  logic [1:0] csSy, sckSy, sdSy;
  logic       sckPrev;
  logic [6:0] shReg;
  logic [2:0] bitCnt;
  frame_e     frame;
  logic [3:0] cmdNum;
  logic [2:0] hiBits;

  logic       csS, sckS, sdS, sckRise, byteDone, execute;
  logic [7:0] rxByte;

  assign csS      = csSy[1];
  assign sckS     = sckSy[1];
  assign sdS      = sdSy[1];
  assign sckRise  = sckS & ~sckPrev;
  assign rxByte   = {shReg, sdS};
  assign byteDone = armed & ~csS & sckRise & (bitCnt == 3'd7);
  assign execute  = byteDone & (frame == FR_TAIL) & ~rxByte[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy    <= 2'b00;
      sckSy   <= 2'b00;
      sdSy    <= 2'b00;
      sckPrev <= 1'b0;
    end else begin
      csSy    <= {csSy[0], csN};
      sckSy   <= {sckSy[0], sclk};
      sdSy    <= {sdSy[0], sdi};
      sckPrev <= sckS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      bitCnt <= '0;
      shReg  <= '0;
      frame  <= FR_HEAD;
      cmdNum <= '0;
      hiBits <= '0;
    end else begin
      if (csS) begin
        // select high: release from reset, drop partial byte and pending head
        armed  <= 1'b1;
        bitCnt <= '0;
        frame  <= FR_HEAD;
      end else if (armed && sckRise) begin
        shReg  <= rxByte[6:0];
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (rxByte[7]) begin
            frame  <= FR_TAIL;
            cmdNum <= rxByte[6:3];
            hiBits <= rxByte[2:0];
          end else begin
            frame <= FR_HEAD;
          end
        end
      end
    end
  end

  always_comb begin
    st         = '0;
    st.payload = {hiBits, rxByte[6:0]};
    st.regIdx  = cmdNum - 4'(FIRST_REG_CMD);
    if (execute) begin
      st.ldPtr  = (cmdNum == 4'd0);
      st.ldHold = (cmdNum == 4'd1);
      st.wrMem  = (cmdNum == 4'd2);
      st.ldReg  = (cmdNum >= 4'(FIRST_REG_CMD)) && (cmdNum <= 4'(LAST_REG_CMD));
    end
  end
endmodule

// File: rtl/sdec_dpath.sv
module sdec_dpath
  import sdec_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       st,
  output logic                          memWe,
  output logic [1:0]                    memTarget,
  output logic [ROW_W-1:0]              memRow,
  output logic [COL_W-1:0]              memCol,
  output logic [2*PAYLOAD_W-1:0]        memData,
  output logic [ROW_W-1:0]              ptrRow,
  output logic [COL_W-1:0]              ptrCol,
  output logic [NUM_REGS*PAYLOAD_W-1:0] ctlRegs,
  output logic                          displayOn
);
  logic                 lineSel;
  logic [PAYLOAD_W-1:0] holdReg;
  logic [PAYLOAD_W-1:0] regBank [NUM_REGS];
  target_e              nextTgt;

  always_comb begin
    if (!lineSel)       nextTgt = TGT_CHAR;
    else if (ptrCol[0]) nextTgt = TGT_MAINLINE;
    else                nextTgt = TGT_SUBLINE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSel   <= 1'b0;
      holdReg   <= '0;
      ptrRow    <= '0;
      ptrCol    <= '0;
      memWe     <= 1'b0;
      memTarget <= '0;
      memRow    <= '0;
      memCol    <= '0;
      memData   <= '0;
    end else begin
      memWe <= 1'b0;
      if (st.ldPtr) begin
        lineSel <= st.payload[9];
        ptrRow  <= ROW_W'(st.payload[8:5]);
        ptrCol  <= COL_W'(st.payload[4:0]);
      end
      if (st.ldHold) holdReg <= st.payload;
      if (st.wrMem) begin
        memWe     <= 1'b1;
        memData   <= {holdReg, st.payload};
        memRow    <= ptrRow;
        memCol    <= ptrCol;
        memTarget <= nextTgt;
        if (ptrCol == COL_W'(COLS - 1)) begin
          ptrCol <= '0;
          ptrRow <= (ptrRow == ROW_W'(ROWS - 1)) ? '0 : ptrRow + 1'b1;
        end else begin
          ptrCol <= ptrCol + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
    end else if (st.ldReg) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (st.regIdx == 4'(i)) regBank[i] <= st.payload;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign ctlRegs[g*PAYLOAD_W +: PAYLOAD_W] = regBank[g];
  end

  assign displayOn = regBank[DISP_SLOT][0];
endmodule

// File: rtl/sdec_top.sv
module sdec_top
  import sdec_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              csN,
  input  logic                              sclk,
  input  logic                              sdi,
  output logic                              memWe,
  output logic [1:0]                        memTarget,
  output logic [$clog2(ROWS)-1:0]           memRow,
  output logic [$clog2(COLS)-1:0]           memCol,
  output logic [2*PAYLOAD_W-1:0]            memData,
  output logic [$clog2(ROWS)-1:0]           ptrRow,
  output logic [$clog2(COLS)-1:0]           ptrCol,
  output logic [NUM_REGS*PAYLOAD_W-1:0]     ctlRegs,
  output logic                              displayOn
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  strobe_t stb;
  logic    armed;

  sdec_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .sdi  (sdi),
    .st   (stb),
    .armed(armed)
  );

  sdec_dpath #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (stb),
    .memWe    (memWe),
    .memTarget(memTarget),
    .memRow   (memRow),
    .memCol   (memCol),
    .memData  (memData),
    .ptrRow   (ptrRow),
    .ptrCol   (ptrCol),
    .ctlRegs  (ctlRegs),
    .displayOn(displayOn)
  );
endmodule

// File: rtl/sdec_chk.sv
module sdec_chk
  import sdec_pkg::*;
#(
  parameter int COLS  = 24,
  parameter int COL_W = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input strobe_t                       st,
  input logic                          armed,
  input logic                          memWe,
  input logic                          displayOn,
  input logic [COL_W-1:0]              ptrCol,
  input logic [NUM_REGS*PAYLOAD_W-1:0] ctlRegs
);
  // R5: write strobe lasts one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R5: a strobe only follows a command-2 execution
  p_we_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(st.wrMem));

  // R6: column wraps after the last column
  p_col_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrMem && ptrCol == COL_W'(COLS - 1)) |=> (ptrCol == '0));

  // R8: register file moves only on a register load strobe
  p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldReg |=> $stable(ctlRegs));

  // R7: at most one action per executed command
  p_one_action_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldPtr, st.ldHold, st.wrMem, st.ldReg}));

  // R10: nothing takes effect before release
  p_dark_until_armed_r10: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!displayOn && !memWe));
endmodule

bind sdec_top sdec_chk #(.COLS(COLS), .COL_W(COL_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .st       (stb),
  .armed    (armed),
  .memWe    (memWe),
  .displayOn(displayOn),
  .ptrCol   (ptrCol),
  .ctlRegs  (ctlRegs)
);

// File: tb/sdec_top_tb_top.sv
module sdec_top_tb_top;
  localparam int NREG = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic        memWe;
  logic [1:0]  memTarget;
  logic [3:0]  memRow;
  logic [4:0]  memCol;
  logic [19:0] memData;
  logic [3:0]  ptrRow;
  logic [4:0]  ptrCol;
  logic [109:0] ctlRegs;
  logic        displayOn;

  int nChecks = 0;
  int nFails = 0;
  int weCnt = 0;
  logic [1:0]  capTgt;
  logic [3:0]  capRow;
  logic [4:0]  capCol;
  logic [19:0] capData;
  logic [9:0]  expReg [NREG];
  bit done = 0;

  always #5 clk = ~clk;

  sdec_top dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .memWe(memWe), .memTarget(memTarget), .memRow(memRow), .memCol(memCol),
    .memData(memData), .ptrRow(ptrRow), .ptrCol(ptrCol),
    .ctlRegs(ctlRegs), .displayOn(displayOn)
  );

  always @(negedge clk) begin
    if (memWe) begin
      weCnt   <= weCnt + 1;
      capTgt  <= memTarget;
      capRow  <= memRow;
      capCol  <= memCol;
      capData <= memData;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sdi = b[i];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendBits(b, 8);
  endtask

  task automatic sendCmd(input logic [3:0] n, input logic [9:0] p);
    sendByte({1'b1, n, p[9:7]});
    sendByte({1'b0, p[6:0]});
  endtask

  task automatic csPulse();
    @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    csN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic chkRegs(input string tag);
    for (int k = 0; k < NREG; k++)
      chk($sformatf("%s slot%0d", tag, k), 64'(ctlRegs[k*10 +: 10]), 64'(expReg[k]));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finishRun();
  end

  initial begin
    int base;
    logic [9:0] h, d;
    for (int k = 0; k < NREG; k++) expReg[k] = '0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 displayOn", 64'(displayOn), 64'd0);
    chk("R9 ctlRegs", 64'(|ctlRegs), 64'd0);
    chk("R9 ptr", 64'({ptrRow, ptrCol}), 64'd0);

    // R10: csN never high yet -> ignored
    sendCmd(4'd4, 10'h3FF);
    sendCmd(4'd0, 10'h0A5);
    chk("R10 displayOn", 64'(displayOn), 64'd0);
    chkRegs("R10");
    chk("R10 ptr", 64'({ptrRow, ptrCol}), 64'd0);

    csPulse();
    // R9/R7: display enable via command 4 bit 0
    sendCmd(4'd4, 10'h001);
    expReg[1] = 10'h001;
    chk("R7 displayOn set", 64'(displayOn), 64'd1);

    // R7/R1: sweep all register commands with asymmetric patterns
    for (int n = 3; n <= 13; n++) begin
      logic [9:0] v;
      v = 10'((n * 37 + 5) ^ (n << 6));
      sendCmd(4'(n), v);
      expReg[n - 3] = v;
      chkRegs($sformatf("R7 cmd%0d", n));
    end
    chk("R7 displayOn follows slot", 64'(displayOn), 64'(expReg[1][0]));

    // R8: reserved commands
    base = weCnt;
    sendCmd(4'd14, 10'h3FF);
    sendCmd(4'd15, 10'h155);
    chkRegs("R8");
    chk("R8 no write", 64'(weCnt), 64'(base));
    chk("R8 ptr", 64'({ptrRow, ptrCol}), 64'd0);

    // R3: stray low-MSB byte in head position
    sendByte(8'h7F);
    chkRegs("R3 stray");
    sendCmd(4'd5, 10'h2C3);
    expReg[2] = 10'h2C3;
    chkRegs("R3 after stray");

    // R11: head byte where tail expected restarts the command
    sendByte({1'b1, 4'd6, 3'b111});
    sendCmd(4'd7, 10'h0F0);
    expReg[4] = 10'h0F0;
    chkRegs("R11");

    // R2: select high drops pending head
    sendByte({1'b1, 4'd8, 3'b101});
    csPulse();
    sendByte(8'h33);
    chkRegs("R2 head dropped");
    // R2: select high drops partial byte
    sendBits(8'hFF, 5);
    csPulse();
    sendCmd(4'd8, 10'h1E1);
    expReg[5] = 10'h1E1;
    chkRegs("R2 partial dropped");

    // R4/R5/R6: sweep every position from 0,0
    sendCmd(4'd0, 10'h000);
    chk("R4 ptr origin", 64'({ptrRow, ptrCol}), 64'd0);
    for (int i = 0; i < 288; i++) begin
      h = 10'((i * 29 + 3) & 10'h3FF);
      d = 10'((i * 53 + 11) & 10'h3FF);
      base = weCnt;
      sendCmd(4'd1, h);
      sendCmd(4'd2, d);
      chk($sformatf("R5 count %0d", i), 64'(weCnt), 64'(base + 1));
      chk($sformatf("R6 write %0d", i), 64'({capTgt, capRow, capCol, capData}),
          64'({2'd0, 4'(i / 24), 5'(i % 24), h, d}));
    end
    chk("R6 full wrap", 64'({ptrRow, ptrCol}), 64'd0);

    // R4/R6: row step at column 23
    sendCmd(4'd0, {1'b0, 4'd5, 5'd23});
    chk("R4 load", 64'({ptrRow, ptrCol}), 64'({4'd5, 5'd23}));
    sendCmd(4'd2, 10'h00F);
    chk("R6 row step", 64'({ptrRow, ptrCol}), 64'({4'd6, 5'd0}));

    // R5: line targets and hold retention
    sendCmd(4'd0, {1'b1, 4'd3, 5'd4});
    sendCmd(4'd1, 10'h2AA);
    sendCmd(4'd2, 10'h011);
    chk("R5 sub line", 64'({capTgt, capRow, capCol, capData}),
        64'({2'd1, 4'd3, 5'd4, 10'h2AA, 10'h011}));
    sendCmd(4'd2, 10'h022);
    chk("R5 main line hold kept", 64'({capTgt, capRow, capCol, capData}),
        64'({2'd2, 4'd3, 5'd5, 10'h2AA, 10'h022}));
    chkRegs("R7 final");

    finishRun();
  end
endmodule